// File: doc/BRIEF.md
# On-Demand DMA Request Handshake Controller

This block sits on the controller side of a shared 32-bit data bus. Through it an external device can ask for DMA service on one of four channels. The device raises a bus-release request. When that request is accepted, the block sends back a one-cycle release indication. Two cycles later the block stops driving the bus, and in that cycle the device may put a request word on the bus together with a transfer strobe. The block captures the word. Its two low bits select the channel, which receives a one-cycle request pulse, and the block records that channel as the most recently requested one.

Two shortcut requests leave the data bus alone. A strobe on its own, outside the capture cycle, repeats the request to the most recently requested channel. A strobe raised in the same cycle as the bus-release request is a direct request to channel 2. A bus-busy input stands in for the rest of the bus controller and holds off new release grants.

Top module: `odt_req_ctrl`

## Requirements
- R1: Reset is synchronous and active high. While it is held and after it is released: the release indication is low, the bus output-enable is high, no channel pulse is raised, the captured word is 0, and the most recently requested channel is 0.
- R2: In an idle cycle, a bus-release request is accepted if it comes without the strobe and with bus-busy low. The release indication is then high for exactly the following cycle.
- R3: A bus-release request is ignored while bus-busy is high or while a release sequence is in progress. No release indication follows it.
- R4: If the release indication is high in cycle k, the bus output-enable is low in cycle k+2.
- R5: If the strobe is high in cycle k+2, the bus word is captured in that cycle. This holds even when the bus-release request is also high. In cycle k+3 the captured-word output shows the word, the channel given by word bits [1:0] pulses for one cycle, and the output-enable is high again. That channel becomes the most recently requested channel.
- R6: If the strobe is low in cycle k+2, no channel pulse follows. The output-enable stays low in cycle k+3, is high in cycle k+4, and the most recently requested channel is unchanged.
- R7: A strobe without the bus-release request, in any cycle other than a capture cycle, pulses the most recently requested channel in the next cycle. The captured word does not change.
- R8: A strobe together with the bus-release request, outside a capture cycle, pulses channel 2 in the next cycle. It starts no release sequence, whatever the state of bus-busy, and leaves the most recently requested channel unchanged.
- R9: At most one bit of the channel pulse output is high in any cycle. Channel n is bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy_i | input | 1 | Rest of the bus controller is busy; hold off grants |
| rel_req_i | input | 1 | Bus-release request from the device |
| strobe_i | input | 1 | Transfer strobe from the device |
| bus_data_i | input | 32 | Shared data bus as seen by the block |
| rel_ack_o | output | 1 | One-cycle release indication |
| bus_oe_o | output | 1 | Output-enable for the controller's own bus drivers |
| chan_req_o | output | 4 | One-cycle request pulse per channel |
| req_word_o | output | 32 | Last captured request word |

## Verification
Every output is registered, so every result is due one clock after the stimulus that causes it. The exceptions are on the bus output-enable: it falls two cycles after the release indication, and it rises either one or two cycles after the capture cycle, depending on whether the strobe arrived. The bench drives each vector in the low half of the clock and samples shortly after the next rising edge. Each table row's expected values therefore describe the cycle right after that row's inputs. The delayed output-enable values are written into the rows where they are due. The most recently requested channel has no port of its own, so the bench reads it out through repeat-request pulses.

// File: rtl/odt_pkg.sv
package odt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRANT,
    ST_HOLD,
    ST_CAPT,
    ST_MISS
  } rel_state_e;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_CAPT,
    RK_REPEAT,
    RK_DIRECT
  } req_kind_e;

endpackage

// File: rtl/odt_release_fsm.sv
module odt_release_fsm
  import odt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic rel_req_i,
  input  logic strobe_i,
  output logic ack_o,
  output logic oe_o,
  output logic capt_win_o
);

  rel_state_e state_q, state_d;
  logic       accept;

  assign accept = (state_q == ST_IDLE) && rel_req_i && !strobe_i && !busy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_GRANT;
      ST_GRANT: state_d = ST_HOLD;
      ST_HOLD:  state_d = ST_CAPT;
      ST_CAPT:  state_d = strobe_i ? ST_IDLE : ST_MISS;
      ST_MISS:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ack_o   <= 1'b0;
      oe_o    <= 1'b1;
    end else begin
      state_q <= state_d;
      ack_o   <= (state_d == ST_GRANT);
      oe_o    <= !((state_d == ST_CAPT) || (state_d == ST_MISS));
    end
  end

  assign capt_win_o = (state_q == ST_CAPT);

endmodule

// File: rtl/odt_req_decode.sv
module odt_req_decode
  import odt_pkg::*;
#(
  parameter int CH_W      = 2,
  parameter int DIRECT_CH = 2
) (
  input  logic            capt_win_i,
  input  logic            rel_req_i,
  input  logic            strobe_i,
  input  logic [CH_W-1:0] word_chan_i,
  input  logic [CH_W-1:0] last_chan_i,
  output req_kind_e       kind_o,
  output logic [CH_W-1:0] chan_o
);

  localparam logic [CH_W-1:0] DIR_IDX = CH_W'(DIRECT_CH);

  always_comb begin
    kind_o = RK_NONE;
    chan_o = last_chan_i;
    if (strobe_i) begin
      if (capt_win_i) begin
        kind_o = RK_CAPT;
        chan_o = word_chan_i;
      end else if (rel_req_i) begin
        kind_o = RK_DIRECT;
        chan_o = DIR_IDX;
      end else begin
        kind_o = RK_REPEAT;
        chan_o = last_chan_i;
      end
    end
  end

endmodule

// File: rtl/odt_req_out.sv
module odt_req_out
  import odt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  req_kind_e         kind_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NUM_CH-1:0] chan_req_o,
  output logic [DATA_W-1:0] word_o,
  output logic [CH_W-1:0]   last_chan_o
);

  logic fire;
  assign fire = (kind_i != RK_NONE);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) chan_req_o[gi] <= 1'b0;
      else     chan_req_o[gi] <= fire && (chan_i == CH_W'(gi));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o      <= '0;
      last_chan_o <= '0;
    end else if (kind_i == RK_CAPT) begin
      word_o      <= data_i;
      last_chan_o <= chan_i;
    end
  end

endmodule

// File: rtl/odt_req_ctrl.sv
module odt_req_ctrl
  import odt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 4,
  parameter int DIRECT_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_busy_i,
  input  logic              rel_req_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              rel_ack_o,
  output logic              bus_oe_o,
  output logic [NUM_CH-1:0] chan_req_o,
  output logic [DATA_W-1:0] req_word_o
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic            capt_win;
  req_kind_e       kind;
  logic [CH_W-1:0] chan;
  logic [CH_W-1:0] last_chan;

  odt_release_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (bus_busy_i),
    .rel_req_i  (rel_req_i),
    .strobe_i   (strobe_i),
    .ack_o      (rel_ack_o),
    .oe_o       (bus_oe_o),
    .capt_win_o (capt_win)
  );

  odt_req_decode #(
    .CH_W      (CH_W),
    .DIRECT_CH (DIRECT_CH)
  ) u_dec (
    .capt_win_i  (capt_win),
    .rel_req_i   (rel_req_i),
    .strobe_i    (strobe_i),
    .word_chan_i (bus_data_i[CH_W-1:0]),
    .last_chan_i (last_chan),
    .kind_o      (kind),
    .chan_o      (chan)
  );

  odt_req_out #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .DATA_W (DATA_W)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .kind_i      (kind),
    .chan_i      (chan),
    .data_i      (bus_data_i),
    .chan_req_o  (chan_req_o),
    .word_o      (req_word_o),
    .last_chan_o (last_chan)
  );

endmodule

// File: rtl/odt_req_ctrl_chk.sv
module odt_req_ctrl_chk #(
  parameter int NUM_CH    = 4,
  parameter int DIRECT_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_busy_i,
  input logic              rel_req_i,
  input logic              strobe_i,
  input logic              rel_ack_o,
  input logic              bus_oe_o,
  input logic [NUM_CH-1:0] chan_req_o
);

  localparam logic [NUM_CH-1:0] DIR_MASK = {{(NUM_CH-1){1'b0}}, 1'b1} << DIRECT_CH;

  // R2: release indication lasts one cycle
  a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
    rel_ack_o |=> !rel_ack_o);

  // R3: release indication only follows an eligible request
  a_r3_ack_cause: assert property (@(posedge clk) disable iff (rst)
    rel_ack_o |-> $past(rel_req_i && !bus_busy_i && !strobe_i));

  // R4: bus released two cycles after the indication
  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    rel_ack_o |=> ##1 !bus_oe_o);

  // R5: strobe in the capture cycle yields a pulse and bus reclaim
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_o && $past(bus_oe_o) && strobe_i) |=>
      (bus_oe_o && $countones(chan_req_o) == 1));

  // R6: bus never released for more than two cycles
  a_r6_reclaim: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_o && $past(!bus_oe_o)) |=> bus_oe_o);

  // R7: lone strobe outside the release window pulses one channel
  a_r7_repeat: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !rel_req_i && bus_oe_o) |=> ($countones(chan_req_o) == 1));

  // R8: combined request targets the direct channel only
  a_r8_direct: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && rel_req_i && bus_oe_o) |=> (chan_req_o == DIR_MASK && !rel_ack_o));

  // R9: channel pulses are exclusive
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_req_o));

endmodule

bind odt_req_ctrl odt_req_ctrl_chk #(
  .NUM_CH    (NUM_CH),
  .DIRECT_CH (DIRECT_CH)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_busy_i (bus_busy_i),
  .rel_req_i  (rel_req_i),
  .strobe_i   (strobe_i),
  .rel_ack_o  (rel_ack_o),
  .bus_oe_o   (bus_oe_o),
  .chan_req_o (chan_req_o)
);

// File: tb/odt_req_ctrl_tb_top.sv
module odt_req_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_busy_i = 1'b0;
  logic        rel_req_i = 1'b0;
  logic        strobe_i = 1'b0;
  logic [31:0] bus_data_i = '0;
  logic        rel_ack_o;
  logic        bus_oe_o;
  logic [3:0]  chan_req_o;
  logic [31:0] req_word_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  odt_req_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_busy_i (bus_busy_i),
    .rel_req_i  (rel_req_i),
    .strobe_i   (strobe_i),
    .bus_data_i (bus_data_i),
    .rel_ack_o  (rel_ack_o),
    .bus_oe_o   (bus_oe_o),
    .chan_req_o (chan_req_o),
    .req_word_o (req_word_o)
  );

  // {busy, rel_req, strobe, data[31:0], exp_ack, exp_oe, exp_req[3:0], exp_word[31:0]}
  localparam int NV = 22;
  localparam logic [72:0] VEC [0:NV-1] = '{
    {3'b000, 32'h0,         1'b0, 1'b1, 4'b0000, 32'h0},
    {3'b001, 32'h0,         1'b0, 1'b1, 4'b0001, 32'h0},
    {3'b010, 32'h0,         1'b1, 1'b1, 4'b0000, 32'h0},
    {3'b000, 32'h0,         1'b0, 1'b1, 4'b0000, 32'h0},
    {3'b000, 32'h0,         1'b0, 1'b0, 4'b0000, 32'h0},
    {3'b001, 32'h0000A5C3,  1'b0, 1'b1, 4'b1000, 32'h0000A5C3},
    {3'b001, 32'h0,         1'b0, 1'b1, 4'b1000, 32'h0000A5C3},
    {3'b011, 32'h0,         1'b0, 1'b1, 4'b0100, 32'h0000A5C3},
    {3'b001, 32'h0,         1'b0, 1'b1, 4'b1000, 32'h0000A5C3},
    {3'b110, 32'h0,         1'b0, 1'b1, 4'b0000, 32'h0000A5C3},
    {3'b000, 32'h0,         1'b0, 1'b1, 4'b0000, 32'h0000A5C3},
    {3'b010, 32'h0,         1'b1, 1'b1, 4'b0000, 32'h0000A5C3},
    {3'b000, 32'h0,         1'b0, 1'b1, 4'b0000, 32'h0000A5C3},
    {3'b000, 32'h0,         1'b0, 1'b0, 4'b0000, 32'h0000A5C3},
    {3'b000, 32'h0000FFFE,  1'b0, 1'b0, 4'b0000, 32'h0000A5C3},
    {3'b000, 32'h0,         1'b0, 1'b1, 4'b0000, 32'h0000A5C3},
    {3'b001, 32'h0,         1'b0, 1'b1, 4'b1000, 32'h0000A5C3},
    {3'b010, 32'h0,         1'b1, 1'b1, 4'b0000, 32'h0000A5C3},
    {3'b010, 32'h0,         1'b0, 1'b1, 4'b0000, 32'h0000A5C3},
    {3'b001, 32'h0,         1'b0, 1'b0, 4'b1000, 32'h0000A5C3},
    {3'b001, 32'h12345671,  1'b0, 1'b1, 4'b0010, 32'h12345671},
    {3'b001, 32'h0,         1'b0, 1'b1, 4'b0010, 32'h12345671}
  };

  function automatic string tag_of(int i);
    case (i)
      0:                return "R1";
      1, 6, 19:         return "R7";
      2, 3, 11, 17:     return "R2";
      4, 12, 13:        return "R4";
      5, 20:            return "R5";
      7, 8:             return "R8";
      9, 10, 18:        return "R3";
      14, 15, 16:       return "R6";
      default:          return "R9";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic busy, logic rr, logic st, logic [31:0] d);
    @(negedge clk);
    bus_busy_i = busy;
    rel_req_i  = rr;
    strobe_i   = st;
    bus_data_i = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(string tag, logic ack, logic oe, logic [3:0] rq, logic [31:0] w);
    check(tag, "rel_ack_o", {31'b0, rel_ack_o}, {31'b0, ack});
    check(tag, "bus_oe_o", {31'b0, bus_oe_o}, {31'b0, oe});
    check(tag, "chan_req_o", {28'b0, chan_req_o}, {28'b0, rq});
    check(tag, "req_word_o", req_word_o, w);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1", 1'b0, 1'b1, 4'b0000, 32'h0);   // R1 during reset
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][72], VEC[i][71], VEC[i][70], VEC[i][69:38]);
      check_all(tag_of(i), VEC[i][37], VEC[i][36], VEC[i][35:32], VEC[i][31:0]);
    end

    // R8: combined request still works while busy, no grant follows
    step(1'b1, 1'b1, 1'b1, 32'h0);
    check_all("R8", 1'b0, 1'b1, 4'b0100, 32'h12345671);
    step(1'b0, 1'b0, 1'b0, 32'h0);
    check_all("R8", 1'b0, 1'b1, 4'b0000, 32'h12345671);

    // R5: request plus strobe in the capture cycle is a capture
    step(1'b0, 1'b1, 1'b0, 32'h0);
    check_all("R5", 1'b1, 1'b1, 4'b0000, 32'h12345671);
    step(1'b0, 1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b0, 1'b0, 32'h0);
    check_all("R5", 1'b0, 1'b0, 4'b0000, 32'h12345671);
    step(1'b0, 1'b1, 1'b1, 32'hCAFE0003);
    check_all("R5", 1'b0, 1'b1, 4'b1000, 32'hCAFE0003);
    step(1'b0, 1'b0, 1'b1, 32'h0);
    check_all("R5", 1'b0, 1'b1, 4'b1000, 32'hCAFE0003);

    // R1: reset in the middle of a release sequence
    step(1'b0, 1'b1, 1'b0, 32'h0);
    @(negedge clk);
    rel_req_i = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1", 1'b0, 1'b1, 4'b0000, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b1, 32'h0);
    check_all("R1", 1'b0, 1'b1, 4'b0001, 32'h0);   // last channel back to 0
    step(1'b0, 1'b0, 1'b0, 32'h0);
    check_all("R9", 1'b0, 1'b1, 4'b0000, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule